// File: doc/BRIEF.md
# DMA Control and Status Register Unit

This unit is the host-facing register file that sets up and launches a DMA transfer. A host writes and reads 32-bit words through a plain register port. The port has an address, write data, a write strobe, a read strobe and registered read data. Behind that port sit four kinds of register:

- a soft-reset register;
- a DMA control register and a DMA status register;
- three DMA parameters: packet size, packet count and destination address;
- an ordinary control register and an ordinary status register for general-purpose use.

The unit drives the external DMA mover with the stored parameters and a one-cycle start pulse. It takes back a busy level and a done pulse from the mover.

A transfer must be set up in a fixed order:

1. Write the soft-reset register, which clears the DMA parameters and status and arms the unit.
2. Load the packet size, packet count and destination address.
3. Write the DMA control register to launch.

A launch that breaks this order is refused and flagged. The order is broken when the unit is not armed, or when size or count is zero. While a transfer runs, the DMA parameters are write-protected.

There is no data stream through this block. Every pin is a plain control or status signal, and reads and writes complete in one cycle with no back-pressure.

Top module: `dmacsr_top`

Register offsets (byte addresses, 32-bit words, the address must match exactly):

| Offset | Register |
|---|---|
| 0x00 | soft reset (write-only, reads 0) |
| 0x04 | DMA control (write-only, reads 0) |
| 0x08 | DMA status |
| 0x0C | packet size |
| 0x10 | packet count |
| 0x14 | destination address |
| 0x18 | ordinary control |
| 0x1C | ordinary status |

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, dma_start, dma_size, dma_count, dma_dest, ord_ctrl and reg_rdata are all 0. The DMA status register reads 0 while dma_busy is low, and the unit is armed.
- R2: Writes to 0x0C, 0x10, 0x14 and 0x18 are stored and read back. Packet size and count keep only their low SIZE_W and CNT_W bits, and the upper bits read 0. The stored values appear on dma_size, dma_count, dma_dest and ord_ctrl.
- R3: A read of any address other than the eight word offsets returns 0, and this includes misaligned addresses. A write to such an address changes no register.
- R4: Writing 1 to bit 0 of 0x00 clears packet size, count, destination, the done bit and the error bit, at the second clock edge after the write. It also re-arms the unit. The ordinary control register is left unchanged, and 0x00 and 0x04 always read 0.
- R5: Writing 1 to bit 0 of 0x04 raises dma_start for exactly one cycle, in the cycle after the write edge. This happens only when the unit is armed, packet size and count are nonzero, and neither dma_busy nor dma_start is high. The launch disarms the unit.
- R6: A start write with packet size or count equal to 0 gives no pulse and sets the config-error flag, which is DMA status bit 2.
- R7: A start write after a launch with no soft reset in between gives no pulse and sets the config-error flag.
- R8: While dma_busy or dma_start is high, writes to 0x0C, 0x10 and 0x14 are ignored. The ordinary control register stays writable.
- R9: DMA status bit 0 shows dma_busy. Bit 1 is set by a dma_done pulse and stays set until a soft reset or rst_n.
- R10: reg_rdata loads the addressed value on each edge where reg_re is high and holds otherwise. Offset 0x1C reads the ord_status input.
- R11: A start write while dma_busy is high gives no pulse and leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_addr | input | ADDR_W | byte address of the access |
| reg_wdata | input | 32 | write data |
| reg_we | input | 1 | write strobe |
| reg_re | input | 1 | read strobe |
| reg_rdata | output | 32 | read data, valid the cycle after reg_re |
| dma_size | output | SIZE_W | packet size to the mover |
| dma_count | output | CNT_W | packet count to the mover |
| dma_dest | output | DEST_W | destination address to the mover |
| dma_start | output | 1 | one-cycle launch pulse |
| dma_busy | input | 1 | mover is running |
| dma_done | input | 1 | mover finished (pulse) |
| ord_ctrl | output | 32 | ordinary control register value |
| ord_status | input | 32 | ordinary status, read at 0x1C |

## Verification
The bench builds the unit with its defaults: an 8-bit address, 16-bit size and count fields, and a 32-bit destination. With 16-bit fields, a 32-bit write to the size register shows the truncation of the upper half. The 8-bit address leaves room for offsets above 0x1C and for misaligned addresses that must decode as unmapped.

A hand-driven model of the mover's busy and done signals exercises the launch order. It covers the locked window, the sticky done bit, a refused second launch, zero-parameter refusals and re-arming after a soft reset.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned REG_BYTES = 4;

  typedef enum logic [2:0] {
    IDX_SRST  = 3'd0,
    IDX_DCTL  = 3'd1,
    IDX_DSTAT = 3'd2,
    IDX_PSIZE = 3'd3,
    IDX_PCNT  = 3'd4,
    IDX_DEST  = 3'd5,
    IDX_OCTL  = 3'd6,
    IDX_OSTAT = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic cfg_err;
    logic done;
    logic busy;
  } dma_stat_t;
endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]                 addr,
  output logic [dmacsr_pkg::NUM_REGS-1:0]   hit
);
  import dmacsr_pkg::*;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(i * REG_BYTES));
  end
endmodule

// File: rtl/dmacsr_cfg.sv
module dmacsr_cfg #(
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              lock,
  input  logic              wr_size,
  input  logic              wr_cnt,
  input  logic              wr_dest,
  input  logic [SIZE_W-1:0] wsize,
  input  logic [CNT_W-1:0]  wcnt,
  input  logic [DEST_W-1:0] wdest,
  output logic [SIZE_W-1:0] size_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DEST_W-1:0] dest_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      size_q <= '0;
      cnt_q  <= '0;
      dest_q <= '0;
    end else if (!lock) begin
      if (wr_size) size_q <= wsize;
      if (wr_cnt)  cnt_q  <= wcnt;
      if (wr_dest) dest_q <= wdest;
    end
  end
endmodule

// File: rtl/dmacsr_launch.sv
module dmacsr_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_srst,
  input  logic wr_ctl,
  input  logic wbit0,
  input  logic size_nz,
  input  logic cnt_nz,
  input  logic dma_busy,
  input  logic dma_done,
  output logic soft_clr,
  output logic dma_start,
  output logic done_q,
  output logic err_q
);
  logic armed_q;
  logic go_req;
  logic idle;
  logic launch;
  logic refuse;

  assign go_req = wr_ctl && wbit0;
  assign idle   = !dma_busy && !dma_start && !soft_clr;
  assign launch = go_req && idle && armed_q && size_nz && cnt_nz;
  assign refuse = go_req && idle && !(armed_q && size_nz && cnt_nz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_clr  <= 1'b0;
      dma_start <= 1'b0;
      armed_q   <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      soft_clr  <= wr_srst && wbit0;
      dma_start <= launch;
      if (soft_clr) begin
        armed_q <= 1'b1;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        if (launch)   armed_q <= 1'b0;
        if (dma_done) done_q  <= 1'b1;
        if (refuse)   err_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [31:0]       reg_rdata,
  output logic [SIZE_W-1:0] dma_size,
  output logic [CNT_W-1:0]  dma_count,
  output logic [DEST_W-1:0] dma_dest,
  output logic              dma_start,
  input  logic              dma_busy,
  input  logic              dma_done,
  output logic [31:0]       ord_ctrl,
  input  logic [31:0]       ord_status
);
  import dmacsr_pkg::*;

  localparam int unsigned DATA_W = 32;

  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wsel;
  logic                soft_clr;
  logic                done_q;
  logic                err_q;
  logic                lock;
  logic [31:0]         octl_q;
  logic [31:0]         rd_next;
  dma_stat_t           stat;

  dmacsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .hit  (hit)
  );

  assign wsel = hit & {NUM_REGS{reg_we}};
  assign lock = dma_busy || dma_start;

  dmacsr_cfg #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .DEST_W(DEST_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .lock     (lock),
    .wr_size  (wsel[IDX_PSIZE]),
    .wr_cnt   (wsel[IDX_PCNT]),
    .wr_dest  (wsel[IDX_DEST]),
    .wsize    (reg_wdata[SIZE_W-1:0]),
    .wcnt     (reg_wdata[CNT_W-1:0]),
    .wdest    (reg_wdata[DEST_W-1:0]),
    .size_q   (dma_size),
    .cnt_q    (dma_count),
    .dest_q   (dma_dest)
  );

  dmacsr_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_srst   (wsel[IDX_SRST]),
    .wr_ctl    (wsel[IDX_DCTL]),
    .wbit0     (reg_wdata[0]),
    .size_nz   (dma_size != '0),
    .cnt_nz    (dma_count != '0),
    .dma_busy  (dma_busy),
    .dma_done  (dma_done),
    .soft_clr  (soft_clr),
    .dma_start (dma_start),
    .done_q    (done_q),
    .err_q     (err_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              octl_q <= '0;
    else if (wsel[IDX_OCTL]) octl_q <= reg_wdata;
  end
  assign ord_ctrl = octl_q;

  assign stat = '{cfg_err: err_q, done: done_q, busy: dma_busy};

  always_comb begin
    rd_next = '0;
    if (hit[IDX_DSTAT]) rd_next = DATA_W'(stat);
    if (hit[IDX_PSIZE]) rd_next = DATA_W'(dma_size);
    if (hit[IDX_PCNT])  rd_next = DATA_W'(dma_count);
    if (hit[IDX_DEST])  rd_next = DATA_W'(dma_dest);
    if (hit[IDX_OCTL])  rd_next = octl_q;
    if (hit[IDX_OSTAT]) rd_next = ord_status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/dmacsr_chk.sv
module dmacsr_chk #(
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_re,
  input logic [31:0]       reg_rdata,
  input logic              dma_start,
  input logic              dma_busy,
  input logic [SIZE_W-1:0] dma_size,
  input logic [CNT_W-1:0]  dma_count,
  input logic [DEST_W-1:0] dma_dest,
  input logic              soft_clr,
  input logic              done_flag
);
  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  // R6
  start_params_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (dma_size != '0) && (dma_count != '0));

  // R11
  start_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> !$past(dma_busy));

  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && !soft_clr) |=> $stable({dma_size, dma_count, dma_dest}));

  // R4
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (dma_size == '0) && (dma_count == '0) && (dma_dest == '0) && !done_flag);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !soft_clr) |=> done_flag);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
endmodule

bind dmacsr_top dmacsr_chk #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .DEST_W(DEST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_re    (reg_re),
  .reg_rdata (reg_rdata),
  .dma_start (dma_start),
  .dma_busy  (dma_busy),
  .dma_size  (dma_size),
  .dma_count (dma_count),
  .dma_dest  (dma_dest),
  .soft_clr  (soft_clr),
  .done_flag (done_q)
);

// File: tb/dmacsr_top_tb.sv
`timescale 1ns/1ps
module dmacsr_top_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SIZE_W = 16;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DEST_W = 32;
  localparam logic [31:0] OSTAT_VAL = 32'h1234_5678;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic              reg_we = 1'b0;
  logic              reg_re = 1'b0;
  logic [31:0]       reg_rdata;
  logic [SIZE_W-1:0] dma_size;
  logic [CNT_W-1:0]  dma_count;
  logic [DEST_W-1:0] dma_dest;
  logic              dma_start;
  logic              dma_busy = 1'b0;
  logic              dma_done = 1'b0;
  logic [31:0]       ord_ctrl;
  logic [31:0]       ord_status = OSTAT_VAL;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dmacsr_top #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .DEST_W(DEST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .dma_size(dma_size), .dma_count(dma_count), .dma_dest(dma_dest),
    .dma_start(dma_start), .dma_busy(dma_busy), .dma_done(dma_done),
    .ord_ctrl(ord_ctrl), .ord_status(ord_status)
  );

  // entry: {is_write, addr[7:0], data[31:0]}; reads compare data as expected value
  localparam int NVEC = 16;
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b1, 8'h0C, 32'h0001_2345},  // R2 size, upper half dropped
    {1'b0, 8'h0C, 32'h0000_2345},  // R2
    {1'b1, 8'h10, 32'h0000_0010},  // R2 count
    {1'b0, 8'h10, 32'h0000_0010},  // R2
    {1'b1, 8'h14, 32'h8000_1000},  // R2 destination
    {1'b0, 8'h14, 32'h8000_1000},  // R2
    {1'b1, 8'h18, 32'hA5A5_5A5A},  // R2 ordinary control
    {1'b0, 8'h18, 32'hA5A5_5A5A},  // R2
    {1'b1, 8'h24, 32'hFFFF_FFFF},  // R3 unmapped write
    {1'b0, 8'h24, 32'h0000_0000},  // R3 unmapped read
    {1'b0, 8'h0E, 32'h0000_0000},  // R3 misaligned read
    {1'b0, 8'h00, 32'h0000_0000},  // R4 reset register reads 0
    {1'b0, 8'h04, 32'h0000_0000},  // R4 control register reads 0
    {1'b0, 8'h08, 32'h0000_0000},  // R9 idle status
    {1'b0, 8'h1C, 32'h1234_5678},  // R10 ordinary status input
    {1'b0, 8'h0C, 32'h0000_2345}   // R3 size untouched by unmapped write
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic soft_reset();
    wr(8'h00, 32'h1);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 start", 32'(dma_start), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 size", 32'(dma_size), 32'h0);
    check("R1 ctrl", ord_ctrl, 32'h0);
    rd(8'h08, 32'h0, "R1 status");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else            rd(VEC[i][39:32], VEC[i][31:0], $sformatf("vec%0d", i));
    end
    check("R2 ord_ctrl port", ord_ctrl, 32'hA5A5_5A5A);

    // R5 launch
    wr(8'h04, 32'h1);
    check("R5 start high", 32'(dma_start), 32'h1);
    check("R5 size port", 32'(dma_size), 32'h2345);
    check("R5 dest port", dma_dest, 32'h8000_1000);
    @(negedge clk);
    check("R5 start single", 32'(dma_start), 32'h0);
    dma_busy = 1'b1;

    // R8 lock while busy
    wr(8'h0C, 32'h7777);
    rd(8'h0C, 32'h2345, "R8 size locked");
    wr(8'h14, 32'h0);
    rd(8'h14, 32'h8000_1000, "R8 dest locked");
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h1, "R8 ord ctrl writable");
    rd(8'h08, 32'h1, "R9 busy bit");

    // R11 start while busy
    wr(8'h04, 32'h1);
    check("R11 no pulse", 32'(dma_start), 32'h0);
    rd(8'h08, 32'h1, "R11 no error");

    // R9 done sticky
    @(negedge clk);
    dma_done = 1'b1; dma_busy = 1'b0;
    @(negedge clk);
    dma_done = 1'b0;
    rd(8'h08, 32'h2, "R9 done set");
    repeat (5) @(negedge clk);
    rd(8'h08, 32'h2, "R9 done sticky");

    // R7 relaunch without reset
    wr(8'h04, 32'h1);
    check("R7 no pulse", 32'(dma_start), 32'h0);
    rd(8'h08, 32'h6, "R7 error flag");

    // R4 soft reset
    soft_reset();
    check("R4 size port", 32'(dma_size), 32'h0);
    rd(8'h0C, 32'h0, "R4 size");
    rd(8'h10, 32'h0, "R4 count");
    rd(8'h14, 32'h0, "R4 dest");
    rd(8'h08, 32'h0, "R4 status");
    rd(8'h18, 32'h1, "R4 ord ctrl kept");
    rd(8'h00, 32'h0, "R4 reset reads 0");

    // R6 zero size
    wr(8'h10, 32'h5);
    wr(8'h04, 32'h1);
    check("R6 zero size no pulse", 32'(dma_start), 32'h0);
    rd(8'h08, 32'h4, "R6 zero size error");

    // R6 zero count
    soft_reset();
    wr(8'h0C, 32'h8);
    wr(8'h04, 32'h1);
    check("R6 zero count no pulse", 32'(dma_start), 32'h0);
    rd(8'h08, 32'h4, "R6 zero count error");

    // R5 re-armed after soft reset
    soft_reset();
    wr(8'h0C, 32'h8);
    wr(8'h10, 32'h3);
    wr(8'h04, 32'h1);
    check("R5 rearmed pulse", 32'(dma_start), 32'h1);
    check("R5 count port", 32'(dma_count), 32'h3);
    @(negedge clk);

    // R10 read data holds
    rd(8'h18, 32'h1, "R10 read");
    @(negedge clk);
    reg_addr = 8'h0C;
    @(negedge clk);
    check("R10 hold", reg_rdata, 32'h1);

    // R1 hardware reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 size after reset", 32'(dma_size), 32'h0);
    check("R1 start after reset", 32'(dma_start), 32'h0);
    rd(8'h18, 32'h0, "R1 ord ctrl after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule